// File: doc/BRIEF.md
# Serial Stop-Clock Command Receiver

This block takes a one-wire command stream and turns it into a set of run/stop enables for a group of gated clock outputs: one graphics clock, one floppy clock, seven bus clocks and four processor clocks. The stream is timed by the bus clock. The sender moves the data line on rising edges, and the receiver samples it on falling edges. The data line rests high. A command opens with a single sampled low, the start bit. Fifteen data bits follow, one per bus clock cycle.

The incoming bits collect in a shift register and do not affect the outputs yet. On the falling edge after the fifteenth data bit, the decoded word is copied as a whole into a holding register, and that register drives the enables. A data bit of 1 lets its clock run and a 0 stops it. The bit-to-output assignment is not sequential, and two bit slots are reserved. Gating of the clocks themselves happens elsewhere.

Top module: `stopclk_cmd_rx`

## Requirements
- R1: While rst_n is low, every enable output is 1 and the receiver is idle.
- R2: sdata is sampled only on falling edges of bclk. While idle, a high sample does nothing, and a low pulse that ends before a falling edge does not start a command.
- R3: A low sample while idle is the start bit. The next 15 falling-edge samples are data bits 1 to 15, in arrival order.
- R4: The enable outputs keep their previous values through the start edge and all 15 data edges. They all change together on the 16th falling edge after the start edge, which is the apply edge.
- R5: An applied data bit of 1 sets its enable to 1 (clock runs). A 0 sets it to 0 (clock stopped).
- R6: Data bit 1 drives graphics_en and data bit 3 drives floppy_en.
- R7: Data bits 4, 5, ... 10 drive bus_en[6], bus_en[5], ... bus_en[0].
- R8: Data bits 12, 13, 14, 15 drive cpu_en[3], cpu_en[2], cpu_en[1], cpu_en[0].
- R9: Data bits 2 and 11 have no effect on any enable.
- R10: After the apply edge the receiver is idle again. A low sampled on the apply edge itself counts as the start bit of the next command, so commands can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock; all state advances on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial command line, idles high |
| graphics_en | output | 1 | Run enable for the graphics clock |
| floppy_en | output | 1 | Run enable for the floppy clock |
| bus_en | output | 7 | Run enables for bus clocks 6..0 |
| cpu_en | output | 4 | Run enables for processor clocks 3..0 |

## Verification
Two things can happen on the same falling edge: the holding register is loaded from a finished command, and the start bit of the next command is detected. The bench produces this by chaining commands, driving the next start bit low in the rising-edge slot that comes right before the apply edge. It then checks that the first command's enables appear exactly on that apply edge. It also checks that the chained command is received with its bits correctly aligned and that it applies 16 edges later, with the expected values computed from the bit mapping.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    // Number of data bits that follow the start bit
    localparam int DATA_BITS = 15;
    localparam int CNT_W     = $clog2(DATA_BITS + 1);

    // Output group sizes
    localparam int BUS_N = 7;
    localparam int CPU_N = 4;

    // 1-based positions of the controlling data bits
    localparam int GFX_POS       = 1;
    localparam int FLP_POS       = 3;
    localparam int BUS_FIRST_POS = 4;   // controls the highest bus clock
    localparam int CPU_FIRST_POS = 12;  // controls the highest processor clock
    localparam int RSV_A_POS     = 2;
    localparam int RSV_B_POS     = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_APPLY = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic             gfx;
        logic             flp;
        logic [BUS_N-1:0] bus;
        logic [CPU_N-1:0] cpu;
    } clk_en_t;

    localparam int EN_W = $bits(clk_en_t);

endpackage

// File: rtl/stopclk_frame_ctrl.sv
module stopclk_frame_ctrl
    import stopclk_pkg::*;
(
    input  logic bclk,
    input  logic rst_n,
    input  logic sdata,
    output logic shift_en,
    output logic apply
);

    typedef struct packed {
        rx_state_e        state;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_BITS - 1);

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (!sdata) begin
                    nxt_d.state = ST_SHIFT;
                    nxt_d.cnt   = '0;
                end
            end
            ST_SHIFT: begin
                if (cur_q.cnt == LAST_CNT) begin
                    nxt_d.state = ST_APPLY;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_APPLY: begin
                // a low here is the start bit of a chained command
                nxt_d.state = sdata ? ST_IDLE : ST_SHIFT;
                nxt_d.cnt   = '0;
            end
            default: begin
                nxt_d.state = ST_IDLE;
                nxt_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign shift_en = (cur_q.state == ST_SHIFT);
    assign apply    = (cur_q.state == ST_APPLY);

    // R3
    cnt_range_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        cur_q.cnt < CNT_W'(DATA_BITS));

    // R3
    start_detect_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (cur_q.state == ST_IDLE && !sdata) |=> (cur_q.state == ST_SHIFT && cur_q.cnt == '0));

    // R4
    frame_len_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (cur_q.state == ST_SHIFT && cur_q.cnt == LAST_CNT) |=> (cur_q.state == ST_APPLY));

    // R10
    apply_single_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (cur_q.state == ST_APPLY) |=> (cur_q.state != ST_APPLY));

endmodule

// File: rtl/stopclk_shifter.sv
module stopclk_shifter #(
    parameter int WIDTH = 15
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdata,
    output logic [WIDTH-1:0] word
);

    logic [WIDTH-1:0] sh_q, sh_d;

    // First bit received ends in position 0 after WIDTH shifts
    always_comb begin
        sh_d = sh_q;
        if (shift_en) begin
            sh_d = {sdata, sh_q[WIDTH-1:1]};
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word = sh_q;

    // R3
    shift_track_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        shift_en |=> (sh_q[WIDTH-1] == $past(sdata)));

endmodule

// File: rtl/stopclk_bit_map.sv
module stopclk_bit_map
    import stopclk_pkg::*;
(
    input  logic [DATA_BITS-1:0] word,
    output clk_en_t              en
);

    assign en.gfx = word[GFX_POS-1];
    assign en.flp = word[FLP_POS-1];

    // bus clocks: first bus bit controls the highest index
    for (genvar k = 0; k < BUS_N; k++) begin : g_bus
        assign en.bus[k] = word[BUS_FIRST_POS + (BUS_N - 1 - k) - 1];
    end

    // processor clocks: first processor bit controls the highest index
    for (genvar k = 0; k < CPU_N; k++) begin : g_cpu
        assign en.cpu[k] = word[CPU_FIRST_POS + (CPU_N - 1 - k) - 1];
    end

    // reserved slots are received but drive nothing
    logic unused_reserved;
    assign unused_reserved = word[RSV_A_POS-1] ^ word[RSV_B_POS-1];

endmodule

// File: rtl/stopclk_cmd_rx.sv
module stopclk_cmd_rx
    import stopclk_pkg::*;
(
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             sdata,
    output logic             graphics_en,
    output logic             floppy_en,
    output logic [BUS_N-1:0] bus_en,
    output logic [CPU_N-1:0] cpu_en
);

    logic                 shift_en;
    logic                 apply;
    logic [DATA_BITS-1:0] word;
    clk_en_t              mapped;
    clk_en_t              hold_q, hold_d;

    stopclk_frame_ctrl u_ctrl (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .sdata    (sdata),
        .shift_en (shift_en),
        .apply    (apply)
    );

    stopclk_shifter #(.WIDTH(DATA_BITS)) u_shift (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdata    (sdata),
        .word     (word)
    );

    stopclk_bit_map u_map (
        .word (word),
        .en   (mapped)
    );

    always_comb begin
        hold_d = hold_q;
        if (apply) begin
            hold_d = mapped;
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '1;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign graphics_en = hold_q.gfx;
    assign floppy_en   = hold_q.flp;
    assign bus_en      = hold_q.bus;
    assign cpu_en      = hold_q.cpu;

    // R4
    hold_gate_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (hold_q != $past(hold_q)) |-> $past(apply));

    // R1
    reset_run_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        $rose(rst_n) |-> (hold_q == EN_W'('1)));

endmodule

// File: tb/tb_stopclk_cmd_rx.sv
module tb_stopclk_cmd_rx;

    logic       bclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdata = 1'b1;
    logic       graphics_en, floppy_en;
    logic [6:0] bus_en;
    logic [3:0] cpu_en;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  started = 1'b0;        // start bit of next command already driven
    logic [12:0] cur_exp = '1;  // {gfx, flp, bus[6:0], cpu[3:0]}

    always #10 bclk = ~bclk;    // 50 MHz

    stopclk_cmd_rx dut (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .sdata       (sdata),
        .graphics_en (graphics_en),
        .floppy_en   (floppy_en),
        .bus_en      (bus_en),
        .cpu_en      (cpu_en)
    );

    // word[i] is data bit i (1..15); word[0] unused
    function automatic logic [12:0] model(input logic [15:0] w);
        logic [6:0] b;
        logic [3:0] c;
        for (int k = 0; k < 7; k++) b[k] = w[10 - k];
        for (int k = 0; k < 4; k++) c[k] = w[15 - k];
        return {w[1], w[3], b, c};
    endfunction

    task automatic check(input string req, input logic [12:0] exp);
        logic [12:0] got;
        got = {graphics_en, floppy_en, bus_en, cpu_en};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: enables got %h expected %h", req, got, exp);
        end
    endtask

    // Called just after a rising edge; returns just after a rising edge.
    task automatic send(input logic [15:0] w, input bit chain, input string req);
        if (!started) begin
            #1 sdata = 1'b0;
            @(posedge bclk);
        end
        for (int i = 1; i <= 15; i++) begin
            #1 sdata = w[i];
            @(posedge bclk);
        end
        check("R4 unchanged before apply", cur_exp);
        #1 sdata = chain ? 1'b0 : 1'b1;
        started = chain;
        @(posedge bclk);
        cur_exp = model(w);
        check(req, cur_exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge bclk);
        check("R1 reset state", 13'h1FFF);
        #1 rst_n = 1'b1;
        @(posedge bclk);

        // R2: idle high does nothing
        repeat (20) @(posedge bclk);
        check("R2 idle high", 13'h1FFF);

        // R2: low pulses that end before the falling edge are not sampled
        for (int i = 0; i < 8; i++) begin
            #1 sdata = 1'b0;
            #5 sdata = 1'b1;
            @(posedge bclk);
        end
        repeat (20) @(posedge bclk);
        check("R2 short low ignored", 13'h1FFF);

        // R5 R6 R7 R8 R9: walking zero across every data bit
        for (int i = 1; i <= 15; i++) begin
            logic [15:0] w;
            w = 16'hFFFF;
            w[i] = 1'b0;
            if (i == 2 || i == 11) send(w, 1'b0, "R9 reserved bit zero");
            else                   send(w, 1'b0, "R5 R6 R7 R8 walking zero");
        end

        // R5: all stop
        send(16'h0000, 1'b0, "R5 all zeros");
        check("R5 all stopped", 13'h0000);

        // R6 R7 R8 R9: walking one from all stopped
        for (int i = 1; i <= 15; i++) begin
            logic [15:0] w;
            w = 16'h0000;
            w[i] = 1'b1;
            if (i == 2 || i == 11) send(w, 1'b0, "R9 reserved bit one");
            else                   send(w, 1'b0, "R6 R7 R8 walking one");
        end

        // R10: back-to-back commands, start bit on the apply edge
        send(16'hAAAA, 1'b1, "R10 chained first");
        send(16'h5554, 1'b1, "R10 chained second");
        send(16'hF0F0, 1'b0, "R10 chained last");

        // R3 R5 R10: pseudo-random words, some chained
        lfsr = 16'hACE1;
        for (int n = 0; n < 40; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr, (n != 39) && lfsr[0], "R3 R5 random command");
            if (!started) begin
                repeat (lfsr[3:2]) @(posedge bclk);
            end
        end

        // R10: after an unchained command the receiver is idle
        repeat (25) @(posedge bclk);
        check("R10 idle after apply", cur_exp);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule